// File: doc/BRIEF.md
# Processor Power Mode Controller

This block steps a processor between five power modes: full on, active (PLL bypassed), sleep, deep sleep and hibernate. It drives enables for the core and system clocks, the PLL bypass select, the PLL enable, the core power request, an external regulator wake line, a pad three-state enable, a flag that blocks DMA into L1 memory, and an internal reset that is held during the hibernate wake sequence. Clocks and power are modelled only as enable levels.

Software changes mode with a 3-bit request code and a valid strobe. It writes a control register that holds the bypass-preference bit and the PLL-off bit. It also writes an interrupt wake mask and a retained regulator register, which holds the hibernate trigger bit and the wake source enables. What happens on a wakeup depends on the mode. Sleep returns on an enabled interrupt. Deep sleep returns only through the reset pin. Hibernate returns on a retained wake source or on the reset pin, and always through a timed reset sequence.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Both clock enables are high in full on and active. In sleep, `cclk_en` is low and `sclk_en` is high. In deep sleep, hibernate and the wake sequence, both are low.
- R2: `pll_bypass` is high only in active. `core_pwr` is low only in hibernate.
- R3: In sleep, an interrupt line set in the wake mask ends sleep. The next mode is full on (code 0) if the bypass-preference bit is 0, and active (code 1) if it is 1. Interrupt lines that are masked off have no effect.
- R4: In deep sleep, interrupts are ignored and requests do not change the mode. Asserting `rst_pin` moves the block to full on.
- R5: `ctl_pll_off` is taken only in active, and `pll_en` is its inverse (it is also low in hibernate). While the PLL is off, requests for full on (0) or sleep (2) are rejected.
- R6: In full on or active, a regulator write with `vreg_hib`=0, or request code 4, enters hibernate. Hibernate drives `ext_wake` low, `core_pwr` low and `pad_tristate` high.
- R7: Hibernate is left when a `wake_src` line enabled in the retained register is high, or when `rst_pin` is high. The wake enables survive hibernate. The bypass bit, the PLL-off bit, the interrupt mask and the error bit are cleared.
- R8: The wake sequence holds `int_rst` high for RST_CYCLES cycles with `ext_wake` high, and then enters full on.
- R9: `dma_l1_block` is high in sleep and low in every other mode.
- R10: A request that is not legal from the current mode leaves the mode unchanged and sets the sticky `req_err`. Codes 5 to 7 are never legal, and any request in sleep or deep sleep is illegal. Requests in hibernate and during the wake sequence are ignored. `req_err` is cleared only by `rst_pin`, by a hibernate wake, or by `por_n`.
- R11: `mode_status` encodes full on=0, active=1, sleep=2, deep sleep=3, hibernate=4. The wake sequence reports 4. It changes at the clock edge that takes the transition.
- R12: `por_n` low gives full on with the PLL enabled, `ext_wake` high, no error, an empty interrupt mask and no wake enables.
- R13: `rst_pin` in full on, active, sleep or deep sleep gives full on and clears the bypass bit, the PLL-off bit, the mask and the error, but keeps the wake enables. Priority in a cycle is `rst_pin`, then a hibernate write, then a request. Register writes are taken only in full on and active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the control logic |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Processor reset pin, synchronous, active high |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| ctl_we | input | 1 | Control register write strobe |
| ctl_bypass | input | 1 | Bypass-preference bit written |
| ctl_pll_off | input | 1 | PLL-off bit written |
| imask_we | input | 1 | Interrupt wake mask write strobe |
| imask_val | input | N_IRQ | Interrupt wake mask value |
| irq | input | N_IRQ | Interrupt lines |
| vreg_we | input | 1 | Retained regulator register write strobe |
| vreg_hib | input | 1 | Hibernate bit written (0 enters hibernate) |
| vreg_wake_en | input | N_WAKE | Hibernate wake source enables written |
| wake_src | input | N_WAKE | Hibernate wake source lines |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| pll_bypass | output | 1 | PLL bypass select |
| pll_en | output | 1 | PLL enable |
| core_pwr | output | 1 | Core power request |
| ext_wake | output | 1 | External regulator wake, low while hibernating |
| pad_tristate | output | 1 | Three-state all pads |
| dma_l1_block | output | 1 | DMA to L1 memory is blocked |
| int_rst | output | 1 | Internal reset during the hibernate wake sequence |
| mode_status | output | 3 | Current mode code |
| req_err | output | 1 | Sticky illegal-request flag |

## Verification
On every cycle, the assertions check that deep sleep is left only through the reset pin, and that an enabled interrupt in sleep lands on the mode chosen by the bypass bit. They also check the pin levels in hibernate, that the wake reset always ends in full on, that a request for full on with the PLL off is refused, and that the error flag falls only on a reset or a wake. The bench scenarios are the only place that shows three things. First, the wake enables survive hibernate while the mask and the bypass bit are lost. Second, masked interrupts and disabled wake sources leave the mode alone. Third, reset, the hibernate write and requests are ordered correctly when they arrive together.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        ST_FULL   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_DEEP   = 3'd3,
        ST_HIBER  = 3'd4,
        ST_WAKE   = 3'd5
    } pm_state_e;

    localparam logic [2:0] CODE_FULL   = 3'd0;
    localparam logic [2:0] CODE_ACTIVE = 3'd1;
    localparam logic [2:0] CODE_SLEEP  = 3'd2;
    localparam logic [2:0] CODE_DEEP   = 3'd3;
    localparam logic [2:0] CODE_HIBER  = 3'd4;

    typedef struct packed {
        logic cclk_en;
        logic sclk_en;
        logic pll_bypass;
        logic core_pwr;
        logic ext_wake;
        logic pad_tristate;
        logic dma_l1_block;
        logic int_rst;
    } pm_pins_t;

endpackage

// File: rtl/pwr_req_check.sv
module pwr_req_check
    import pwr_mode_pkg::*;
(
    input  pm_state_e   st,
    input  logic [2:0]  code,
    input  logic        pll_off,
    output logic        legal
);
    logic awake;

    always_comb begin
        awake = (st == ST_FULL) || (st == ST_ACTIVE);
        legal = 1'b0;
        if (awake) begin
            case (code)
                CODE_FULL:   legal = (st == ST_FULL) || !pll_off;
                CODE_ACTIVE: legal = 1'b1;
                CODE_SLEEP:  legal = !pll_off;
                CODE_DEEP:   legal = 1'b1;
                CODE_HIBER:  legal = 1'b1;
                default:     legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int N_IRQ  = 8,
    parameter int N_WAKE = 4
) (
    input  logic [N_IRQ-1:0]  irq,
    input  logic [N_IRQ-1:0]  irq_mask,
    input  logic [N_WAKE-1:0] wake_src,
    input  logic [N_WAKE-1:0] wake_en,
    output logic              irq_hit,
    output logic              src_hit
);
    logic [N_IRQ-1:0]  irq_arm;
    logic [N_WAKE-1:0] src_arm;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        assign irq_arm[i] = irq[i] & irq_mask[i];
    end

    for (genvar j = 0; j < N_WAKE; j++) begin : g_src
        assign src_arm[j] = wake_src[j] & wake_en[j];
    end

    assign irq_hit = |irq_arm;
    assign src_hit = |src_arm;
endmodule

// File: rtl/pwr_vreg_keep.sv
module pwr_vreg_keep #(
    parameter int N_WAKE = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr,
    input  logic [N_WAKE-1:0] wr_val,
    output logic [N_WAKE-1:0] wake_en
);
    logic [N_WAKE-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr) en_d = wr_val;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign wake_en = en_q;
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
    import pwr_mode_pkg::*;
(
    input  pm_state_e  st,
    output pm_pins_t   pins,
    output logic [2:0] status
);
    always_comb begin
        pins = '{cclk_en: 1'b0, sclk_en: 1'b0, pll_bypass: 1'b0, core_pwr: 1'b1,
                 ext_wake: 1'b1, pad_tristate: 1'b0, dma_l1_block: 1'b0, int_rst: 1'b0};
        status = 3'(st);
        case (st)
            ST_FULL: begin
                pins.cclk_en = 1'b1;
                pins.sclk_en = 1'b1;
            end
            ST_ACTIVE: begin
                pins.cclk_en    = 1'b1;
                pins.sclk_en    = 1'b1;
                pins.pll_bypass = 1'b1;
            end
            ST_SLEEP: begin
                pins.sclk_en      = 1'b1;
                pins.dma_l1_block = 1'b1;
            end
            ST_DEEP: begin
            end
            ST_HIBER: begin
                pins.core_pwr     = 1'b0;
                pins.ext_wake     = 1'b0;
                pins.pad_tristate = 1'b1;
            end
            ST_WAKE: begin
                pins.pad_tristate = 1'b1;
                pins.int_rst      = 1'b1;
                status            = CODE_HIBER;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int N_IRQ      = 8,
    parameter int N_WAKE     = 4,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic              ctl_we,
    input  logic              ctl_bypass,
    input  logic              ctl_pll_off,
    input  logic              imask_we,
    input  logic [N_IRQ-1:0]  imask_val,
    input  logic [N_IRQ-1:0]  irq,
    input  logic              vreg_we,
    input  logic              vreg_hib,
    input  logic [N_WAKE-1:0] vreg_wake_en,
    input  logic [N_WAKE-1:0] wake_src,
    output logic              cclk_en,
    output logic              sclk_en,
    output logic              pll_bypass,
    output logic              pll_en,
    output logic              core_pwr,
    output logic              ext_wake,
    output logic              pad_tristate,
    output logic              dma_l1_block,
    output logic              int_rst,
    output logic [2:0]        mode_status,
    output logic              req_err
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    typedef struct packed {
        pm_state_e        st;
        logic             byp;
        logic             poff;
        logic [N_IRQ-1:0] mask;
        logic             err;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic              awake;
    logic              legal;
    logic              irq_hit;
    logic              src_hit;
    logic [N_WAKE-1:0] wake_en;
    pm_pins_t          pins;

    assign awake = (r_q.st == ST_FULL) || (r_q.st == ST_ACTIVE);

    pwr_req_check u_req (
        .st      (r_q.st),
        .code    (req_mode),
        .pll_off (r_q.poff),
        .legal   (legal)
    );

    pwr_wake_detect #(.N_IRQ(N_IRQ), .N_WAKE(N_WAKE)) u_wake (
        .irq      (irq),
        .irq_mask (r_q.mask),
        .wake_src (wake_src),
        .wake_en  (wake_en),
        .irq_hit  (irq_hit),
        .src_hit  (src_hit)
    );

    pwr_vreg_keep #(.N_WAKE(N_WAKE)) u_vreg (
        .clk     (clk),
        .por_n   (por_n),
        .wr      (vreg_we && awake),
        .wr_val  (vreg_wake_en),
        .wake_en (wake_en)
    );

    always_comb begin
        r_d = r_q;
        if (awake) begin
            if (ctl_we) begin
                r_d.byp = ctl_bypass;
                if (r_q.st == ST_ACTIVE) r_d.poff = ctl_pll_off;
            end
            if (imask_we) r_d.mask = imask_val;
        end
        case (r_q.st)
            ST_FULL, ST_ACTIVE: begin
                if (rst_pin) begin
                    r_d      = '0;
                    r_d.st   = ST_FULL;
                end else if (vreg_we && !vreg_hib) begin
                    r_d.st = ST_HIBER;
                end else if (req_valid) begin
                    if (legal) r_d.st = pm_state_e'(req_mode);
                    else       r_d.err = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (rst_pin) begin
                    r_d    = '0;
                    r_d.st = ST_FULL;
                end else if (irq_hit) begin
                    r_d.st = r_q.byp ? ST_ACTIVE : ST_FULL;
                end else if (req_valid) begin
                    r_d.err = 1'b1;
                end
            end
            ST_DEEP: begin
                if (rst_pin) begin
                    r_d    = '0;
                    r_d.st = ST_FULL;
                end else if (req_valid) begin
                    r_d.err = 1'b1;
                end
            end
            ST_HIBER: begin
                if (rst_pin || src_hit) begin
                    r_d    = '0;
                    r_d.st = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.st  = ST_FULL;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                r_d    = '0;
                r_d.st = ST_FULL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    pwr_out_decode u_out (
        .st     (r_q.st),
        .pins   (pins),
        .status (mode_status)
    );

    assign cclk_en      = pins.cclk_en;
    assign sclk_en      = pins.sclk_en;
    assign pll_bypass   = pins.pll_bypass;
    assign core_pwr     = pins.core_pwr;
    assign ext_wake     = pins.ext_wake;
    assign pad_tristate = pins.pad_tristate;
    assign dma_l1_block = pins.dma_l1_block;
    assign int_rst      = pins.int_rst;
    assign pll_en       = !r_q.poff && (r_q.st != ST_HIBER);
    assign req_err      = r_q.err;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       rst_pin,
    input logic       req_valid,
    input logic [2:0] req_mode,
    input logic       vreg_we,
    input logic       vreg_hib,
    input logic       irq_hit,
    input logic       byp_q,
    input logic [2:0] mode_status,
    input logic       cclk_en,
    input logic       sclk_en,
    input logic       core_pwr,
    input logic       ext_wake,
    input logic       pad_tristate,
    input logic       pll_en,
    input logic       int_rst,
    input logic       req_err
);
    a_r4_deep_holds: assert property (@(posedge clk) disable iff (!por_n)
        (mode_status == 3'd3 && !rst_pin) |=> (mode_status == 3'd3));

    a_r4_deep_exit: assert property (@(posedge clk) disable iff (!por_n)
        (mode_status == 3'd3 && rst_pin) |=> (mode_status == 3'd0));

    a_r3_sleep_wake: assert property (@(posedge clk) disable iff (!por_n)
        (mode_status == 3'd2 && !rst_pin && irq_hit) |=>
        (mode_status == ($past(byp_q) ? 3'd1 : 3'd0)));

    a_r6_hib_pins: assert property (@(posedge clk) disable iff (!por_n)
        (mode_status == 3'd4 && !int_rst) |->
        (!ext_wake && !core_pwr && pad_tristate && !cclk_en && !sclk_en));

    a_r8_wake_end: assert property (@(posedge clk) disable iff (!por_n)
        $fell(int_rst) |-> (mode_status == 3'd0 && ext_wake));

    a_r5_pll_guard: assert property (@(posedge clk) disable iff (!por_n)
        (mode_status == 3'd1 && !pll_en && req_valid && req_mode == 3'd0 &&
         !rst_pin && !(vreg_we && !vreg_hib)) |=> (mode_status == 3'd1 && req_err));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!por_n)
        $fell(req_err) |-> ($past(rst_pin) || int_rst));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .rst_pin      (rst_pin),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .vreg_we      (vreg_we),
    .vreg_hib     (vreg_hib),
    .irq_hit      (irq_hit),
    .byp_q        (r_q.byp),
    .mode_status  (mode_status),
    .cclk_en      (cclk_en),
    .sclk_en      (sclk_en),
    .core_pwr     (core_pwr),
    .ext_wake     (ext_wake),
    .pad_tristate (pad_tristate),
    .pll_en       (pll_en),
    .int_rst      (int_rst),
    .req_err      (req_err)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 8;
    localparam int NW = 4;
    localparam int RC = 8;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin, req_valid, ctl_we, ctl_bypass, ctl_pll_off, imask_we, vreg_we, vreg_hib;
    logic [2:0] req_mode;
    logic [NI-1:0] imask_val, irq;
    logic [NW-1:0] vreg_wake_en, wake_src;
    logic cclk_en, sclk_en, pll_bypass, pll_en, core_pwr, ext_wake, pad_tristate;
    logic dma_l1_block, int_rst, req_err;
    logic [2:0] mode_status;

    int checks = 0;
    int errors = 0;

    int m_st, m_cnt;
    bit m_byp, m_poff, m_err;
    bit [NI-1:0] m_mask;
    bit [NW-1:0] m_ven;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(NI), .N_WAKE(NW), .RST_CYCLES(RC)) u_dut (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .req_valid(req_valid),
        .req_mode(req_mode), .ctl_we(ctl_we), .ctl_bypass(ctl_bypass),
        .ctl_pll_off(ctl_pll_off), .imask_we(imask_we), .imask_val(imask_val),
        .irq(irq), .vreg_we(vreg_we), .vreg_hib(vreg_hib),
        .vreg_wake_en(vreg_wake_en), .wake_src(wake_src), .cclk_en(cclk_en),
        .sclk_en(sclk_en), .pll_bypass(pll_bypass), .pll_en(pll_en),
        .core_pwr(core_pwr), .ext_wake(ext_wake), .pad_tristate(pad_tristate),
        .dma_l1_block(dma_l1_block), .int_rst(int_rst), .mode_status(mode_status),
        .req_err(req_err)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit legal_req(int st, int code, bit poff);
        if (st != 0 && st != 1) return 1'b0;
        case (code)
            0: return (st == 0) || !poff;
            1, 3, 4: return 1'b1;
            2: return !poff;
            default: return 1'b0;
        endcase
    endfunction

    task automatic idle();
        rst_pin = 0; req_valid = 0; req_mode = 0; ctl_we = 0; ctl_bypass = 0;
        ctl_pll_off = 0; imask_we = 0; imask_val = 0; irq = 0; vreg_we = 0;
        vreg_hib = 1; vreg_wake_en = 0; wake_src = 0;
    endtask

    task automatic clear_model(int st);
        m_st = st; m_byp = 0; m_poff = 0; m_mask = 0; m_err = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        int st = m_st;
        bit awake = (st == 0) || (st == 1);
        bit lg = legal_req(st, req_mode, m_poff);
        if (awake) begin
            if (ctl_we) begin
                m_byp = ctl_bypass;
                if (st == 1) m_poff = ctl_pll_off;
            end
            if (imask_we) m_mask = imask_val;
            if (vreg_we) m_ven = vreg_wake_en;
        end
        case (st)
            0, 1: begin
                if (rst_pin) clear_model(0);
                else if (vreg_we && !vreg_hib) m_st = 4;
                else if (req_valid) begin
                    if (lg) m_st = req_mode;
                    else m_err = 1;
                end
            end
            2: begin
                if (rst_pin) clear_model(0);
                else if ((irq & m_mask) != 0) m_st = m_byp ? 1 : 0;
                else if (req_valid) m_err = 1;
            end
            3: begin
                if (rst_pin) clear_model(0);
                else if (req_valid) m_err = 1;
            end
            4: if (rst_pin || (wake_src & m_ven) != 0) clear_model(5);
            default: begin
                if (m_cnt == RC - 1) begin m_st = 0; m_cnt = 0; end
                else m_cnt++;
            end
        endcase
    endtask

    // one clock: update model with current inputs, then compare at the next falling edge
    task automatic cyc(string tag);
        int s;
        model_step();
        @(negedge clk);
        s = m_st;
        chk(tag, mode_status, (s == 5) ? 4 : s);                         // status per mode
        chk("R1", cclk_en, (s == 0 || s == 1));
        chk("R1", sclk_en, (s == 0 || s == 1 || s == 2));
        chk("R2", pll_bypass, (s == 1));
        chk("R2", core_pwr, (s != 4));
        chk("R5", pll_en, !m_poff && s != 4);
        chk("R6", ext_wake, (s != 4));
        chk("R6", pad_tristate, (s == 4 || s == 5));
        chk("R8", int_rst, (s == 5));
        chk("R9", dma_l1_block, (s == 2));
        chk("R10", req_err, m_err);
        idle();
    endtask

    task automatic req(int code, string tag);
        req_valid = 1; req_mode = 3'(code); cyc(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        clear_model(0); m_ven = 0;
        repeat (3) @(negedge clk);
        por_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12", mode_status, 0); chk("R12", pll_en, 1);
        chk("R12", ext_wake, 1);    chk("R12", req_err, 0);

        // R3 sleep wake: masked line ignored, enabled line returns to active
        imask_we = 1; imask_val = 8'h01; ctl_we = 1; ctl_bypass = 1; cyc("R11");
        req(2, "R11");
        irq = 8'h02; cyc("R3");
        irq = 8'h03; cyc("R3");
        // R5 PLL off in active blocks full on and sleep
        ctl_we = 1; ctl_bypass = 1; ctl_pll_off = 1; cyc("R5");
        req(0, "R5");
        req(2, "R5");
        // R13 reset pin clears error and returns to full on
        rst_pin = 1; cyc("R13");
        // R3 with bypass bit clear lands in full on
        imask_we = 1; imask_val = 8'h80; cyc("R3");
        req(2, "R3");
        irq = 8'h80; cyc("R3");
        // R4 deep sleep
        req(3, "R4");
        irq = 8'hFF; cyc("R4");
        req(0, "R4");
        rst_pin = 1; cyc("R4");
        // R6/R7 hibernate through the regulator write
        vreg_we = 1; vreg_wake_en = 4'b0010; vreg_hib = 1; cyc("R6");
        imask_we = 1; imask_val = 8'h01; ctl_we = 1; ctl_bypass = 1; cyc("R7");
        vreg_we = 1; vreg_wake_en = 4'b0010; vreg_hib = 0; cyc("R6");
        wake_src = 4'b0001; cyc("R7");
        req(1, "R10");
        wake_src = 4'b0010; cyc("R7");
        for (int i = 0; i < RC; i++) cyc("R8");
        // mask cleared by the wake: interrupt does not end sleep
        req(2, "R7");
        irq = 8'h01; cyc("R7");
        rst_pin = 1; cyc("R13");
        // R7 retained enables after a second hibernate entered by code 4
        req(4, "R6");
        wake_src = 4'b0010; cyc("R7");
        for (int i = 0; i < RC; i++) cyc("R8");
        // R10 illegal code, R13 priority of hibernate write over request
        req(6, "R10");
        req(1, "R10");
        vreg_we = 1; vreg_hib = 0; vreg_wake_en = 4'b0010; req_valid = 1; req_mode = 3'd3; cyc("R13");
        rst_pin = 1; cyc("R7");
        for (int i = 0; i < RC; i++) cyc("R8");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            rst_pin = ($urandom_range(0, 59) == 0);
            req_valid = ($urandom_range(0, 5) == 0);
            req_mode = 3'($urandom_range(0, 7));
            ctl_we = ($urandom_range(0, 7) == 0);
            ctl_bypass = 1'($urandom);
            ctl_pll_off = 1'($urandom);
            imask_we = ($urandom_range(0, 7) == 0);
            imask_val = NI'($urandom);
            irq = ($urandom_range(0, 9) == 0) ? NI'($urandom) : '0;
            vreg_we = ($urandom_range(0, 19) == 0);
            vreg_hib = ($urandom_range(0, 2) != 0);
            vreg_wake_en = NW'($urandom);
            wake_src = ($urandom_range(0, 9) == 0) ? NW'($urandom) : '0;
            cyc("R11");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule